// File: doc/BRIEF.md
# Object-to-Cache-Line Request Splitter

This block takes one pre-execution request that describes a memory object by its starting byte address and its length in bytes. It breaks that request into one request for each 64-byte cache line the object covers. Each line request carries the aligned line address, the first and last byte that the object occupies inside that line, and a flag on the final piece. It also carries the request kind and the thread, transaction and pre-execution tags, copied unchanged from the input. Later logic uses these to pair each line-level pre-execution result with the real write when that write arrives.

The input and output sides each use a valid/ready handshake. A two-state controller runs the block. In ST_IDLE the input is ready. Transition T_DROP accepts a zero-length request and stays in ST_IDLE without producing any output. Transition T_START accepts a non-empty request, captures it, and moves to ST_EMIT. In ST_EMIT one line request is offered per cycle. Transition T_HOLD keeps the piece stable while the output is stalled. Transition T_STEP advances to the next higher line after a handshake on a non-final piece. Transition T_DONE returns to ST_IDLE after the final piece is handed off.

Top module: `osplit_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Every out_line_addr has its low six bits zero, and the first piece's line address equals in_addr with its low six bits cleared.
- R3: Pieces come out in ascending line order, 64 bytes apart, one per cycle while out_ready is high. Their count is floor(((in_addr mod 64) + in_size - 1) / 64) + 1.
- R4: out_first_byte is in_addr mod 64 on the first piece and 0 on later pieces. out_last_byte is (in_addr + in_size - 1) mod 64 on the final piece and 63 on earlier pieces.
- R5: out_last is 1 on the final piece only. After that piece is handed off, out_valid falls and in_ready rises in the next cycle.
- R6: out_kind and the three tag outputs equal the values captured with the request. The kind encoding is 2'b01 address-dependent, 2'b10 data-dependent and 2'b11 both-dependent.
- R7: A request with in_size equal to 0 is accepted in the cycle it is offered and produces no output piece.
- R8: While pieces are pending, in_ready is 0, and a request offered on the input is ignored: the pending pieces keep their captured address, ranges, kind and tags.
- R9: While out_valid is high and out_ready is low, every output field stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Object request offered |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | ADDR_W | Object start byte address |
| in_size | input | SIZE_W | Object length in bytes |
| in_kind | input | 2 | Dependency kind |
| in_pre_id | input | PRE_W | Pre-execution identifier |
| in_thr_id | input | THR_W | Thread identifier |
| in_txn_id | input | TXN_W | Transaction identifier |
| out_valid | output | 1 | Line request offered |
| out_ready | input | 1 | Consumer takes the line request |
| out_line_addr | output | ADDR_W | Line-aligned address |
| out_first_byte | output | 6 | First object byte in the line |
| out_last_byte | output | 6 | Last object byte in the line |
| out_last | output | 1 | Final piece of the object |
| out_kind | output | 2 | Copied dependency kind |
| out_pre_id | output | PRE_W | Copied pre-execution identifier |
| out_thr_id | output | THR_W | Copied thread identifier |
| out_txn_id | output | TXN_W | Copied transaction identifier |

## Verification
The properties assume that an object never runs past the top of the address space, so start plus length minus one does not wrap. The ascending-line property depends on that assumption. The stimulus places every object well below the top address and sweeps start offsets across a line against lengths that end just before, on and just after line boundaries. While pieces are pending the input stays asserted with a conflicting request, which exercises the input-ignored property without breaking the handshake rules. A pseudo-random stall pattern on out_ready covers the stability property.

// File: rtl/osplit_pkg.sv
package osplit_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_ADDR = 2'b01,
        KIND_DATA = 2'b10,
        KIND_BOTH = 2'b11
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

endpackage

// File: rtl/osplit_ctrl.sv
module osplit_ctrl
    import osplit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_zero,
    input  logic out_ready,
    input  logic at_end,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic advance
);

    state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_START, T_DROP, T_HOLD, T_STEP, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && !in_zero) state_d = ST_EMIT;   // T_START
            end
            ST_EMIT: begin
                if (out_ready && at_end) state_d = ST_IDLE;    // T_DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid && !in_zero;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                advance   = out_ready && !at_end;              // T_STEP
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/osplit_cursor.sv
module osplit_cursor #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 12,
    parameter int PRE_W      = 8,
    parameter int THR_W      = 4,
    parameter int TXN_W      = 8,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [1:0]        in_kind,
    input  logic [PRE_W-1:0]  in_pre_id,
    input  logic [THR_W-1:0]  in_thr_id,
    input  logic [TXN_W-1:0]  in_txn_id,
    output logic [ADDR_W-1:0] cur_line,
    output logic [ADDR_W-1:0] end_line,
    output logic [OFF_W-1:0]  start_off,
    output logic [OFF_W-1:0]  end_off,
    output logic              is_first,
    output logic [1:0]        kind,
    output logic [PRE_W-1:0]  pre_id,
    output logic [THR_W-1:0]  thr_id,
    output logic [TXN_W-1:0]  txn_id
);

    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] last_byte_addr;
    assign last_byte_addr = in_addr + ADDR_W'(in_size) - ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line  <= '0;
            end_line  <= '0;
            start_off <= '0;
            end_off   <= '0;
            is_first  <= 1'b0;
            kind      <= '0;
            pre_id    <= '0;
            thr_id    <= '0;
            txn_id    <= '0;
        end else if (load) begin
            cur_line  <= {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end_line  <= {last_byte_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            start_off <= in_addr[OFF_W-1:0];
            end_off   <= last_byte_addr[OFF_W-1:0];
            is_first  <= 1'b1;
            kind      <= in_kind;
            pre_id    <= in_pre_id;
            thr_id    <= in_thr_id;
            txn_id    <= in_txn_id;
        end else if (advance) begin
            cur_line  <= cur_line + LINE_STEP;
            is_first  <= 1'b0;
        end
    end

endmodule

// File: rtl/osplit_piece.sv
module osplit_piece #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [ADDR_W-1:0] cur_line,
    input  logic [ADDR_W-1:0] end_line,
    input  logic [OFF_W-1:0]  start_off,
    input  logic [OFF_W-1:0]  end_off,
    input  logic              is_first,
    output logic [OFF_W-1:0]  first_byte,
    output logic [OFF_W-1:0]  last_byte,
    output logic              at_end
);

    localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(LINE_BYTES - 1);

    always_comb begin
        at_end     = (cur_line == end_line);
        first_byte = is_first ? start_off : '0;
        last_byte  = at_end ? end_off : TOP_OFF;
    end

endmodule

// File: rtl/osplit_top.sv
module osplit_top #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 12,
    parameter int PRE_W      = 8,
    parameter int THR_W      = 4,
    parameter int TXN_W      = 8,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [1:0]        in_kind,
    input  logic [PRE_W-1:0]  in_pre_id,
    input  logic [THR_W-1:0]  in_thr_id,
    input  logic [TXN_W-1:0]  in_txn_id,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_line_addr,
    output logic [OFF_W-1:0]  out_first_byte,
    output logic [OFF_W-1:0]  out_last_byte,
    output logic              out_last,
    output logic [1:0]        out_kind,
    output logic [PRE_W-1:0]  out_pre_id,
    output logic [THR_W-1:0]  out_thr_id,
    output logic [TXN_W-1:0]  out_txn_id
);

    logic              load, advance, at_end, is_first, in_zero;
    logic [ADDR_W-1:0] cur_line, end_line;
    logic [OFF_W-1:0]  start_off, end_off;

    assign in_zero = (in_size == '0);

    osplit_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_zero   (in_zero),
        .out_ready (out_ready),
        .at_end    (at_end),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .advance   (advance)
    );

    osplit_cursor #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PRE_W(PRE_W),
        .THR_W(THR_W), .TXN_W(TXN_W), .LINE_BYTES(LINE_BYTES)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .in_addr   (in_addr),
        .in_size   (in_size),
        .in_kind   (in_kind),
        .in_pre_id (in_pre_id),
        .in_thr_id (in_thr_id),
        .in_txn_id (in_txn_id),
        .cur_line  (cur_line),
        .end_line  (end_line),
        .start_off (start_off),
        .end_off   (end_off),
        .is_first  (is_first),
        .kind      (out_kind),
        .pre_id    (out_pre_id),
        .thr_id    (out_thr_id),
        .txn_id    (out_txn_id)
    );

    osplit_piece #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
    ) u_piece (
        .cur_line   (cur_line),
        .end_line   (end_line),
        .start_off  (start_off),
        .end_off    (end_off),
        .is_first   (is_first),
        .first_byte (out_first_byte),
        .last_byte  (out_last_byte),
        .at_end     (at_end)
    );

    assign out_line_addr = cur_line;
    assign out_last      = at_end;

endmodule

// File: rtl/osplit_checker.sv
module osplit_checker #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 12,
    parameter int PRE_W      = 8,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [SIZE_W-1:0] in_size,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_line_addr,
    input logic [OFF_W-1:0]  out_first_byte,
    input logic [OFF_W-1:0]  out_last_byte,
    input logic              out_last,
    input logic [1:0]        out_kind,
    input logic [PRE_W-1:0]  out_pre_id
);

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_line_addr[OFF_W-1:0] == '0));                       // R2

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (out_valid && out_line_addr == $past(out_line_addr) + ADDR_W'(LINE_BYTES))); // R3

    AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_first_byte <= out_last_byte));                      // R4

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));    // R5

    AST_TAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            ($stable(out_kind) && $stable(out_pre_id)));                       // R6

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_size == '0) |=> !out_valid);               // R7

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);                                              // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_line_addr) && $stable(out_first_byte)
             && $stable(out_last_byte) && $stable(out_last)));                 // R9

endmodule

bind osplit_top osplit_checker #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PRE_W(PRE_W), .LINE_BYTES(LINE_BYTES)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_size        (in_size),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_line_addr  (out_line_addr),
    .out_first_byte (out_first_byte),
    .out_last_byte  (out_last_byte),
    .out_last       (out_last),
    .out_kind       (out_kind),
    .out_pre_id     (out_pre_id)
);

// File: tb/tb_osplit_top.sv
`timescale 1ns/1ps
module tb_osplit_top;

    localparam int AW = 32;
    localparam int SW = 12;
    localparam int PW = 8;
    localparam int HW = 4;
    localparam int XW = 8;
    localparam int LB = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic [SW-1:0] in_size = '0;
    logic [1:0]    in_kind = '0;
    logic [PW-1:0] in_pre_id = '0;
    logic [HW-1:0] in_thr_id = '0;
    logic [XW-1:0] in_txn_id = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_line_addr;
    logic [5:0]    out_first_byte, out_last_byte;
    logic          out_last;
    logic [1:0]    out_kind;
    logic [PW-1:0] out_pre_id;
    logic [HW-1:0] out_thr_id;
    logic [XW-1:0] out_txn_id;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    osplit_top dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_size(in_size), .in_kind(in_kind), .in_pre_id(in_pre_id),
        .in_thr_id(in_thr_id), .in_txn_id(in_txn_id),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_line_addr(out_line_addr), .out_first_byte(out_first_byte),
        .out_last_byte(out_last_byte), .out_last(out_last),
        .out_kind(out_kind), .out_pre_id(out_pre_id),
        .out_thr_id(out_thr_id), .out_txn_id(out_txn_id)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_req(input longint addr, input int size, input int kind,
                           input int pre, input int thr, input int txn, input int seed);
        longint base, last_addr, line_exp;
        int     npieces, p, cyc, fb, lb;
        bit     stall;
        @(negedge clk);
        in_addr   = AW'(addr);
        in_size   = SW'(size);
        in_kind   = 2'(kind);
        in_pre_id = PW'(pre);
        in_thr_id = HW'(thr);
        in_txn_id = XW'(txn);
        in_valid  = 1'b1;
        check(in_ready == 1'b1, "R7", "in_ready when offered", in_ready, 1);
        @(negedge clk);
        if (size == 0) begin
            in_valid = 1'b0;
            check(out_valid == 1'b0, "R7", "zero-size out_valid", out_valid, 0);
            check(in_ready == 1'b1, "R7", "zero-size in_ready", in_ready, 1);
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "zero-size later out_valid", out_valid, 0);
            return;
        end
        // conflicting request held on the input while busy (R8)
        in_addr   = AW'(addr + 4096 + 17);
        in_size   = SW'(200);
        in_kind   = 2'(kind ^ 3);
        in_pre_id = PW'(~pre);
        in_thr_id = HW'(~thr);
        in_txn_id = XW'(~txn);
        base      = addr & ~longint'(LB - 1);
        last_addr = addr + size - 1;
        npieces   = int'(((addr % LB) + size - 1) / LB) + 1;
        p   = 0;
        cyc = 0;
        while (p < npieces) begin
            stall     = ((cyc * 37 + seed) % 5) == 0;
            out_ready = !stall;
            cyc++;
            line_exp = base + longint'(p) * LB;
            fb = (p == 0) ? int'(addr % LB) : 0;
            lb = (p == npieces - 1) ? int'(last_addr % LB) : LB - 1;
            check(out_valid == 1'b1, "R3", "out_valid during emission", out_valid, 1);
            check(in_ready == 1'b0, "R8", "in_ready while busy", in_ready, 0);
            check(longint'(out_line_addr) == line_exp, "R2", "line address", out_line_addr, line_exp);
            check(int'(out_first_byte) == fb, "R4", "first byte", out_first_byte, fb);
            check(int'(out_last_byte) == lb, "R4", "last byte", out_last_byte, lb);
            check(out_last == (p == npieces - 1), "R5", "last flag", out_last, (p == npieces - 1));
            check(int'(out_kind) == kind, "R6", "kind", out_kind, kind);
            check(int'(out_pre_id) == (pre % 256), "R6", "pre id", out_pre_id, pre % 256);
            check(int'(out_thr_id) == (thr % 16), "R6", "thread id", out_thr_id, thr % 16);
            check(int'(out_txn_id) == (txn % 256), "R6", "txn id", out_txn_id, txn % 256);
            @(negedge clk);
            if (!stall) p++;
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R5", "out_valid after final", out_valid, 0);
        check(in_ready == 1'b1, "R5", "in_ready after final", in_ready, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "busy-time request not taken", out_valid, 0);
    endtask

    initial begin
        int sizes[10] = '{1, 2, 55, 63, 64, 65, 127, 128, 129, 300};
        int req_n = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "post-reset out_valid", out_valid, 0);
        for (int off = 0; off < LB; off += 9) begin
            for (int s = 0; s < 10; s++) begin
                run_req(longint'(32'h0004_0000) + longint'(req_n) * 8192 + off,
                        sizes[s], (req_n % 3) + 1, req_n * 7, req_n, req_n * 3 + 1, req_n);
                req_n++;
            end
            run_req(longint'(32'h0100_0000) + off, 0, 2, off, 1, 2, off);
        end
        // final byte of a line and first byte of the next
        run_req(longint'(32'h0200_003F), 2, 3, 5, 6, 7, 3);
        run_req(longint'(32'h0200_0040), 64, 1, 9, 10, 11, 4);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule